// File: doc/BRIEF.md
# Receiver Datapath Reset Sequencer

This block restarts the receive datapath of a multi-lane serial transceiver. For each lane it issues the 2-bit receive power command, the 2-bit transmit power command and a receive elastic-buffer reset. A restart request makes the lane pass through a fixed handshake. First the receiver is commanded off, and the block waits for an acknowledge edge, which is when clock recovery stops. Then the receiver is commanded back on, and the block waits for a second acknowledge edge. Last, the buffer reset is pulsed for a single cycle and the lane reports ready.

While the transceiver-wide reset or the initialization phase is active, every lane's power commands are driven to the off code. A per-lane park input places one lane in low power without disturbing the others. In bonded mode every lane follows lane 0's request and acknowledge, so only lane 0's commands have an effect. If an acknowledge edge does not arrive within a parameterized number of cycles, a timeout flag is raised and the lane returns to idle.

Top module: `rxrs_top`

## Requirements
- R1: Power codes are 2'b00 for normal and 2'b10 for off. After reset is released, an idle lane drives its receive command at 2'b10 and its transmit command at 2'b00.
- R2: A restart request sampled on a rising edge makes the receive command 2'b10 from the next cycle. The command stays at 2'b10 until an acknowledge edge is detected.
- R3: A step advances only on a low-to-high transition of the lane's acknowledge, where the previous cycle's acknowledge was low. An acknowledge held high from earlier never advances a step.
- R4: The second acknowledge edge moves the receive command to 2'b00 permanently. It also raises the buffer reset for exactly one cycle.
- R5: Ready rises in the cycle after the buffer reset pulse. Ready falls in the cycle after a new request is sampled or the global reset is sampled.
- R6: While the global reset or the initialization input is high, every lane's receive and transmit commands are 2'b10 in that same cycle. The sequence returns to idle.
- R7: A high park bit forces that lane's receive and transmit commands to 2'b10. The other lanes are unaffected.
- R8: With TIMEOUT_CYCLES = T, a lane waiting for an acknowledge returns to idle on the T-th edge after it entered the wait state. On that edge its timeout flag goes high. A new request clears the flag.
- R9: A request that arrives during any step restarts the sequence at the off step.
- R10: With bonded high, lanes 1 and above follow lane 0's request and acknowledge. Their own request and acknowledge inputs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive user clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| xcvr_rst | input | 1 | Transceiver-wide reset; forces codes off |
| init_busy | input | 1 | Initialization in progress; forces codes off |
| bonded | input | 1 | Lanes follow lane 0 |
| restart_req | input | LANES | Per-lane restart request |
| rx_ack | input | LANES | Per-lane power-state acknowledge |
| lane_park | input | LANES | Per-lane low-power control |
| rx_pd | output | LANES x 2 | Receive power command per lane |
| tx_pd | output | LANES x 2 | Transmit power command per lane |
| buf_rst | output | LANES | One-cycle receive buffer reset |
| rx_ready | output | LANES | Lane restarted and ready |
| ack_timeout | output | LANES | Acknowledge did not arrive in time |

## Verification
If the sequencer state is wrong, the receive command shows it one cycle after the edge that should have moved it. For example, a skipped wait shows 2'b00 while the bench still expects 2'b10. A lost pulse shows as a missing buf_rst in the cycle after the second acknowledge edge. A timer that is off by one moves the timeout flag one edge early or late, which the bench checks edge by edge. A bonded lane that reads its own inputs diverges from lane 0 at the next request.

// File: rtl/rxrs_pkg.sv
package rxrs_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_OFF_WAIT,
      ST_ON_WAIT,
      ST_PULSE,
      ST_RUN
   } seq_st_t;

   localparam logic [1:0] PD_RUN = 2'b00;
   localparam logic [1:0] PD_OFF = 2'b10;
endpackage

// File: rtl/rxrs_ack_edge.sv
module rxrs_ack_edge (
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   output logic ack_rise
);
   logic ack_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= ack;
   end

   assign ack_rise = ack & ~ack_q;
endmodule

// File: rtl/rxrs_lane_seq.sv
module rxrs_lane_seq
   import rxrs_pkg::*;
#(
   parameter int TIMEOUT_CYCLES = 1000
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       hold,
   input  logic       req,
   input  logic       ack_rise,
   output logic [1:0] cmd,
   output logic       buf_rst,
   output logic       ready,
   output logic       tmo_err
);
   localparam int TW = (TIMEOUT_CYCLES > 2) ? $clog2(TIMEOUT_CYCLES) : 1;
   localparam logic [TW-1:0] TMR_LAST = TW'(TIMEOUT_CYCLES - 1);

   generate
      if (TIMEOUT_CYCLES < 2) begin : g_bad_tmo
         $error("TIMEOUT_CYCLES must be at least 2");
      end
   endgenerate

   seq_st_t        st;
   logic [TW-1:0]  tmr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         tmr     <= '0;
         tmo_err <= 1'b0;
      end else if (hold) begin
         st      <= ST_IDLE;
         tmr     <= '0;
         tmo_err <= 1'b0;
      end else if (req) begin
         st      <= ST_OFF_WAIT;
         tmr     <= '0;
         tmo_err <= 1'b0;
      end else begin
         unique case (st)
            ST_OFF_WAIT, ST_ON_WAIT: begin
               if (ack_rise) begin
                  st  <= (st == ST_OFF_WAIT) ? ST_ON_WAIT : ST_PULSE;
                  tmr <= '0;
               end else if (tmr == TMR_LAST) begin
                  st      <= ST_IDLE;
                  tmr     <= '0;
                  tmo_err <= 1'b1;
               end else begin
                  tmr <= tmr + 1'b1;
               end
            end
            ST_PULSE: st <= ST_RUN;
            default:  st <= st;
         endcase
      end
   end

   always_comb begin
      cmd     = (st == ST_ON_WAIT || st == ST_PULSE || st == ST_RUN) ? PD_RUN : PD_OFF;
      buf_rst = (st == ST_PULSE);
      ready   = (st == ST_RUN);
   end

   a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      buf_rst |=> !buf_rst);

   a_r5_ready_after_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ready) |-> $past(buf_rst));

   a_r3_on_needs_edge: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == PD_RUN && $past(cmd) == PD_OFF && !$past(req) && !$past(hold))
         |-> $past(ack_rise));

   a_r8_timer_bound: assert property (@(posedge clk) disable iff (!rst_n)
      tmr <= TMR_LAST);
endmodule

// File: rtl/rxrs_pd_force.sv
module rxrs_pd_force
   import rxrs_pkg::*;
(
   input  logic       force_off,
   input  logic       park,
   input  logic [1:0] seq_cmd,
   output logic [1:0] rx_cmd,
   output logic [1:0] tx_cmd
);
   always_comb begin
      rx_cmd = (force_off || park) ? PD_OFF : seq_cmd;
      tx_cmd = (force_off || park) ? PD_OFF : PD_RUN;
   end
endmodule

// File: rtl/rxrs_top.sv
module rxrs_top
   import rxrs_pkg::*;
#(
   parameter int LANES          = 4,
   parameter int TIMEOUT_CYCLES = 1000
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  xcvr_rst,
   input  logic                  init_busy,
   input  logic                  bonded,
   input  logic [LANES-1:0]      restart_req,
   input  logic [LANES-1:0]      rx_ack,
   input  logic [LANES-1:0]      lane_park,
   output logic [LANES-1:0][1:0] rx_pd,
   output logic [LANES-1:0][1:0] tx_pd,
   output logic [LANES-1:0]      buf_rst,
   output logic [LANES-1:0]      rx_ready,
   output logic [LANES-1:0]      ack_timeout
);
   logic hold;
   assign hold = xcvr_rst | init_busy;

   generate
      if (LANES < 1) begin : g_bad_lanes
         $error("LANES must be at least 1");
      end
   endgenerate

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic       req_sel, ack_sel, ack_rise;
      logic [1:0] seq_cmd;

      if (i == 0) begin : g_lead
         assign req_sel = restart_req[0];
         assign ack_sel = rx_ack[0];
      end else begin : g_follow
         assign req_sel = bonded ? restart_req[0] : restart_req[i];
         assign ack_sel = bonded ? rx_ack[0]      : rx_ack[i];
      end

      rxrs_ack_edge u_edge (
         .clk      (clk),
         .rst_n    (rst_n),
         .ack      (ack_sel),
         .ack_rise (ack_rise)
      );

      rxrs_lane_seq #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_seq (
         .clk      (clk),
         .rst_n    (rst_n),
         .hold     (hold),
         .req      (req_sel),
         .ack_rise (ack_rise),
         .cmd      (seq_cmd),
         .buf_rst  (buf_rst[i]),
         .ready    (rx_ready[i]),
         .tmo_err  (ack_timeout[i])
      );

      rxrs_pd_force u_force (
         .force_off (hold),
         .park      (lane_park[i]),
         .seq_cmd   (seq_cmd),
         .rx_cmd    (rx_pd[i]),
         .tx_cmd    (tx_pd[i])
      );

      a_r6_forced_off: assert property (@(posedge clk) disable iff (!rst_n)
         hold |-> (rx_pd[i] == PD_OFF && tx_pd[i] == PD_OFF));

      a_r6_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
         hold |=> !rx_ready[i]);

      a_r7_park_off: assert property (@(posedge clk) disable iff (!rst_n)
         lane_park[i] |-> (rx_pd[i] == PD_OFF && tx_pd[i] == PD_OFF && !rx_ready[i]) or !lane_park[i] or rx_ready[i]);
   end
endmodule

// File: tb/rxrs_top_bench.sv
`timescale 1ns/1ps
module rxrs_top_bench;
   localparam int L   = 4;
   localparam int TMO = 8;
   localparam logic [1:0] OFF = 2'b10;
   localparam logic [1:0] ON  = 2'b00;

   logic clk = 1'b0;
   logic rst_n, xcvr_rst, init_busy, bonded;
   logic [L-1:0] restart_req, rx_ack, lane_park;
   logic [L-1:0][1:0] rx_pd, tx_pd;
   logic [L-1:0] buf_rst, rx_ready, ack_timeout;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #10 clk = ~clk;

   rxrs_top #(.LANES(L), .TIMEOUT_CYCLES(TMO)) u_rxrs_top (
      .clk(clk), .rst_n(rst_n), .xcvr_rst(xcvr_rst), .init_busy(init_busy),
      .bonded(bonded), .restart_req(restart_req), .rx_ack(rx_ack),
      .lane_park(lane_park), .rx_pd(rx_pd), .tx_pd(tx_pd), .buf_rst(buf_rst),
      .rx_ready(rx_ready), .ack_timeout(ack_timeout)
   );

   task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(posedge clk);
      @(negedge clk);
   endtask

   // finish the two handshakes from the off-wait step; ack of lane l low on entry
   task automatic finish_seq(int l);
      rx_ack[l] = 1'b1; step(1);
      chk("R2 off step left on edge", rx_pd[l], ON);
      step(2);
      chk("R3 held ack no advance", buf_rst[l], 0);
      chk("R3 held ack cmd", rx_pd[l], ON);
      rx_ack[l] = 1'b0; step(1);
      rx_ack[l] = 1'b1; step(1);
      chk("R4 buffer pulse", buf_rst[l], 1);
      chk("R4 not ready during pulse", rx_ready[l], 0);
      rx_ack[l] = 1'b0; step(1);
      chk("R4 pulse one cycle", buf_rst[l], 0);
      chk("R5 ready after pulse", rx_ready[l], 1);
      chk("R4 cmd stays on", rx_pd[l], ON);
   endtask

   task automatic run_seq(int l);
      rx_ack[l] = 1'b1; step(2);            // stale high acknowledge
      restart_req[l] = 1'b1; step(1);
      restart_req[l] = 1'b0;
      chk("R2 off command", rx_pd[l], OFF);
      chk("R5 ready low in sequence", rx_ready[l], 0);
      step(3);
      chk("R3 stale ack ignored", rx_pd[l], OFF);
      rx_ack[l] = 1'b0; step(1);
      finish_seq(l);
   endtask

   initial begin
      rst_n = 0; xcvr_rst = 1; init_busy = 0; bonded = 0;
      restart_req = '0; rx_ack = '0; lane_park = '0;
      step(2);
      rst_n = 1; step(1);
      for (int i = 0; i < L; i++) begin
         chk("R6 rx off in global reset", rx_pd[i], OFF);
         chk("R6 tx off in global reset", tx_pd[i], OFF);
         chk("R5 not ready at reset", rx_ready[i], 0);
      end
      xcvr_rst = 0; init_busy = 1; step(1);
      for (int i = 0; i < L; i++) chk("R6 tx off in init", tx_pd[i], OFF);
      init_busy = 0; step(1);
      for (int i = 0; i < L; i++) begin
         chk("R1 idle rx off", rx_pd[i], OFF);
         chk("R1 idle tx on", tx_pd[i], ON);
      end

      // sweep every lane independently
      for (int l = 0; l < L; l++) begin
         run_seq(l);
         for (int k = 0; k < L; k++) begin
            chk("R10 lanes independent rx", rx_pd[k], (k <= l) ? ON : OFF);
            chk("R10 lanes independent ready", rx_ready[k], (k <= l) ? 1 : 0);
         end
      end

      // request while running, then restart mid sequence
      restart_req[0] = 1; step(1); restart_req[0] = 0;
      chk("R5 ready drops on request", rx_ready[0], 0);
      chk("R9 restart from run", rx_pd[0], OFF);
      rx_ack[0] = 1; step(1); rx_ack[0] = 0;
      chk("R2 on step reached", rx_pd[0], ON);
      restart_req[0] = 1; step(1); restart_req[0] = 0;
      chk("R9 restart mid sequence", rx_pd[0], OFF);
      finish_seq(0);

      // timeout on lane 1
      restart_req[1] = 1; step(1); restart_req[1] = 0;
      step(TMO - 1);
      chk("R8 no timeout before limit", ack_timeout[1], 0);
      chk("R8 still waiting", rx_pd[1], OFF);
      step(1);
      chk("R8 timeout flag", ack_timeout[1], 1);
      step(2);
      chk("R8 idle after timeout", rx_pd[1], OFF);
      chk("R8 flag sticky", ack_timeout[1], 1);
      restart_req[1] = 1; step(1); restart_req[1] = 0;
      chk("R8 request clears flag", ack_timeout[1], 0);
      rx_ack[1] = 0; step(1);
      finish_seq(1);

      // park one lane
      lane_park[2] = 1; step(1);
      for (int k = 0; k < L; k++) begin
         chk("R7 park tx", tx_pd[k], (k == 2) ? OFF : ON);
         chk("R7 park rx", rx_pd[k], (k == 2) ? OFF : ON);
      end
      lane_park[2] = 0; step(1);
      chk("R7 unpark restores", rx_pd[2], ON);

      // global reset while running
      xcvr_rst = 1; #1;
      chk("R6 immediate force", rx_pd[0], OFF);
      step(1);
      chk("R5 ready drops on global reset", rx_ready[0], 0);
      xcvr_rst = 0; step(1);
      for (int k = 0; k < L; k++) chk("R6 back to idle", rx_pd[k], OFF);

      // bonded mode
      bonded = 1; step(1);
      restart_req[2] = 1; rx_ack[3] = 1; step(1); restart_req[2] = 0;
      rx_ack[3] = 0; step(1);
      chk("R10 lane request ignored", rx_pd[2], OFF);
      run_seq(0);
      for (int k = 0; k < L; k++) begin
         chk("R10 bonded ready", rx_ready[k], 1);
         chk("R10 bonded rx", rx_pd[k], ON);
      end
      restart_req[1] = 1; step(1); restart_req[1] = 0;
      chk("R10 follower request ignored", rx_ready[1], 1);

      if (!done) begin
         done = 1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      #(20 * 200000);
      if (!done) begin
         done = 1;
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual running expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end
endmodule